// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block guesses where an indirect jump will go before its register-based address computation is finished. It keeps a table of destination addresses, one per slot, chosen by a slice of the jump's own address. A fetch stage presents a jump address on the lookup port and receives, in the same cycle, the address currently held in that slot. The slot carries no owner identification and no confidence state. Any two jumps that land on the same slot share it, and each one overwrites the other's address.

When an indirect jump resolves, the execute stage presents its address and its real destination on the update port. In that same cycle the block compares the held address with the real destination and raises a mispredict flag when they differ. At the next clock edge it stores the real destination. Direct jumps are assumed always right: they never write the table and never flag a mispredict. Conditional branch direction and return addresses are handled elsewhere.

Top module: `jump_target_predictor`

## Requirements
- R1: After reset every slot reads as address zero, so a lookup of any never-written jump address predicts 0.
- R2: The slot number is the jump address shifted right by two and taken modulo ENTRIES (default 2048, a power of two). Slot = pc[IDX_W+1:2].
- R3: An update with up_valid=1 and up_indirect=1 stores up_target in the slot of up_pc at the clock edge. A later lookup of that address returns it.
- R4: A slot always holds the most recent destination written to it. Older values are lost.
- R5: Two jump addresses that differ only in bits above the slot field share one slot, and an update through either is seen by lookups through both.
- R6: Bits 1:0 of a jump address have no effect on the slot chosen.
- R7: When a lookup and an update hit the same slot in the same cycle, the lookup returns the old contents. The new value is visible from the next cycle.
- R8: An update with up_indirect=0 writes nothing, and mispredict stays 0.
- R9: pred_valid is 1 exactly when lk_valid=1 and lk_indirect=1.
- R10: mispredict is 1, in the same cycle as the update, exactly when up_valid=1, up_indirect=1 and the slot of up_pc holds a value other than up_target.
- R11: An update leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears all slots to zero |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_indirect | input | 1 | The looked-up jump is indirect |
| lk_pc | input | ADDR_W | Address of the jump being looked up |
| pred_valid | output | 1 | Prediction applies to this lookup |
| pred_target | output | ADDR_W | Predicted destination (held slot contents) |
| up_valid | input | 1 | A resolved jump is presented this cycle |
| up_indirect | input | 1 | The resolved jump is indirect |
| up_pc | input | ADDR_W | Address of the resolved jump |
| up_target | input | ADDR_W | Real destination of the resolved jump |
| mispredict | output | 1 | Held slot value differs from the real destination |

## Verification
Lookups of untouched addresses right after reset separate a cleared table from stale or undefined contents. Addresses that differ only in bits 1:0, only above the slot field, or by one word test the slot decode: the first two must hit the same slot and the third must not. Repeated writes to one slot, first with new and then with identical destinations, expose whether the last write wins and whether the mispredict compare is true equality. A lookup and update to the same slot in one cycle, plus direct-jump updates, show the read-before-write ordering and the write gating.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

  // Slot number of a jump address: word-aligned address, modulo table size.
  function automatic logic [63:0] slot_of(input logic [63:0] pc,
                                          input int unsigned entries);
    logic [63:0] word;
    word = pc >> 2;
    return word & (64'(entries) - 64'd1);
  endfunction

  // A resolved indirect jump disagrees with what the table held.
  function automatic logic differs(input logic [63:0] held,
                                   input logic [63:0] actual);
    return held != actual;
  endfunction

endpackage

// File: rtl/jtp_table.sv
module jtp_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 2048,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [ADDR_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [ADDR_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data
);

  // Written-flags are reset; the address storage itself is not.
  logic [ENTRIES-1:0] written_q;
  logic [ADDR_W-1:0]  addr_mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= '0;
    end else if (wr_en) begin
      written_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_mem[wr_idx] <= wr_data;
    end
  end

  // Asynchronous reads: a same-cycle write is seen only after the edge.
  assign rd_a_data = written_q[rd_a_idx] ? addr_mem[rd_a_idx] : '0;
  assign rd_b_data = written_q[rd_b_idx] ? addr_mem[rd_b_idx] : '0;

endmodule

// File: rtl/jtp_resolve.sv
module jtp_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              up_valid,
  input  logic              up_indirect,
  input  logic [ADDR_W-1:0] held_target,
  input  logic [ADDR_W-1:0] real_target,
  output logic              wr_en,
  output logic              miss
);

  logic indirect_done;

  assign indirect_done = up_valid && up_indirect;
  assign wr_en         = indirect_done;
  assign miss          = indirect_done &&
                         jtp_pkg::differs(64'(held_target), 64'(real_target));

endmodule

// File: rtl/jump_target_predictor.sv
module jump_target_predictor #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 2048,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_indirect,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              up_valid,
  input  logic              up_indirect,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_target,
  output logic              mispredict
);

  // Named internal events, also used by the bound checker.
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  up_idx;
  logic [ADDR_W-1:0] upd_held;
  logic              wr_en;

  assign lk_idx = IDX_W'(jtp_pkg::slot_of(64'(lk_pc), ENTRIES));
  assign up_idx = IDX_W'(jtp_pkg::slot_of(64'(up_pc), ENTRIES));

  jtp_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (lk_idx),
    .rd_a_data (pred_target),
    .rd_b_idx  (up_idx),
    .rd_b_data (upd_held),
    .wr_en     (wr_en),
    .wr_idx    (up_idx),
    .wr_data   (up_target)
  );

  jtp_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .up_valid    (up_valid),
    .up_indirect (up_indirect),
    .held_target (upd_held),
    .real_target (up_target),
    .wr_en       (wr_en),
    .miss        (mispredict)
  );

  assign pred_valid = lk_valid && lk_indirect;

endmodule

// File: rtl/jtp_checker.sv
module jtp_checker #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 2048,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_target,
  input logic              up_valid,
  input logic              up_indirect,
  input logic [ADDR_W-1:0] up_target,
  input logic [IDX_W-1:0]  up_idx,
  input logic [ADDR_W-1:0] upd_held,
  input logic              wr_en,
  input logic              mispredict
);

  // R1: first cycle out of reset reads zero
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pred_target == '0);

  // R3: a written value is read back through the same slot next cycle
  p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!(up_idx == $past(up_idx)) || upd_held == $past(up_target)));

  // R8: direct jumps never write
  p_no_write_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> up_indirect);

  // R8: direct jumps never flag
  p_quiet_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_indirect) |-> !mispredict);

  // R9: no prediction without a lookup
  p_pred_needs_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> lk_valid);

  // R10: a flag implies a resolved indirect jump with a differing slot
  p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (up_valid && up_indirect && upd_held != up_target));

endmodule

bind jump_target_predictor jtp_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .pred_valid  (pred_valid),
  .pred_target (pred_target),
  .up_valid    (up_valid),
  .up_indirect (up_indirect),
  .up_target   (up_target),
  .up_idx      (up_idx),
  .upd_held    (upd_held),
  .wr_en       (wr_en),
  .mispredict  (mispredict)
);

// File: tb/sim_jump_target_predictor.sv
module sim_jump_target_predictor;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int ENTRIES    = 2048;
  localparam logic [31:0] SPAN = 32'(ENTRIES) * 32'd4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_valid = 1'b0, lk_indirect = 1'b0;
  logic [ADDR_W-1:0] lk_pc = '0;
  logic              pred_valid;
  logic [ADDR_W-1:0] pred_target;
  logic              up_valid = 1'b0, up_indirect = 1'b0;
  logic [ADDR_W-1:0] up_pc = '0, up_target = '0;
  logic              mispredict;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_target_predictor #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_indirect(lk_indirect), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_target(pred_target),
    .up_valid(up_valid), .up_indirect(up_indirect), .up_pc(up_pc),
    .up_target(up_target), .mispredict(mispredict)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Combinational lookup, sampled mid-cycle after the negative edge.
  task automatic peek(input logic [31:0] pc, output logic [31:0] tgt);
    @(negedge clk);
    lk_valid = 1'b1; lk_indirect = 1'b1; lk_pc = pc;
    #1;
    tgt = pred_target;
    lk_valid = 1'b0;
  endtask

  // One update cycle; returns the flag seen before the write edge.
  task automatic resolve(input logic [31:0] pc, input logic [31:0] tgt,
                         input logic ind, output logic flag);
    @(negedge clk);
    up_valid = 1'b1; up_indirect = ind; up_pc = pc; up_target = tgt;
    #1;
    flag = mispredict;
    @(posedge clk);
    #1;
    up_valid = 1'b0; up_indirect = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] t;
    peek(32'h0000_1000, t); check("R1 fresh slot", t, 0);
    peek(32'hFFFF_FFFC, t); check("R1 top slot", t, 0);
  endtask

  task automatic t_write_read();
    logic f; logic [31:0] t;
    resolve(32'h0000_1000, 32'hABCD_0000, 1'b1, f);
    check("R10 flag on first resolve", f, 1);
    peek(32'h0000_1000, t); check("R3 readback", t, 32'hABCD_0000);
  endtask

  task automatic t_overwrite();
    logic f; logic [31:0] t;
    resolve(32'h0000_1000, 32'h1234_5678, 1'b1, f);
    check("R10 flag on change", f, 1);
    peek(32'h0000_1000, t); check("R4 last wins", t, 32'h1234_5678);
    resolve(32'h0000_1000, 32'h1234_5678, 1'b1, f);
    check("R10 no flag when equal", f, 0);
  endtask

  task automatic t_alias();
    logic f; logic [31:0] t;
    peek(32'h0000_1000 + SPAN, t); check("R5 alias reads shared slot", t, 32'h1234_5678);
    resolve(32'h0000_1000 + 2*SPAN, 32'h0BAD_F00C, 1'b1, f);
    peek(32'h0000_1000, t); check("R5 alias write seen", t, 32'h0BAD_F00C);
    check("R2 slot field", 64'((32'h0000_1000 >> 2) % ENTRIES), 64'(32'h400));
  endtask

  task automatic t_lowbits();
    logic [31:0] t;
    peek(32'h0000_1003, t); check("R6 low bits ignored", t, 32'h0BAD_F00C);
    peek(32'h0000_1004, t); check("R11 neighbour untouched", t, 0);
    peek(32'h0000_0FFC, t); check("R11 lower neighbour untouched", t, 0);
  endtask

  task automatic t_direct();
    logic f; logic [31:0] t;
    resolve(32'h0000_2000, 32'h5555_5554, 1'b0, f);
    check("R8 direct no flag", f, 0);
    peek(32'h0000_2000, t); check("R8 direct no write", t, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] t;
    @(negedge clk);
    lk_valid = 1'b1; lk_indirect = 1'b1; lk_pc = 32'h0000_4000;
    up_valid = 1'b1; up_indirect = 1'b1; up_pc = 32'h0000_4000; up_target = 32'h7777_0000;
    #1;
    check("R7 old value same cycle", pred_target, 0);
    @(posedge clk); #1;
    up_valid = 1'b0;
    check("R7 new value next cycle", pred_target, 32'h7777_0000);
    lk_valid = 1'b0;
  endtask

  task automatic t_valid();
    @(negedge clk);
    lk_valid = 1'b1; lk_indirect = 1'b0; #1;
    check("R9 direct lookup", pred_valid, 0);
    lk_indirect = 1'b1; #1;
    check("R9 indirect lookup", pred_valid, 1);
    lk_valid = 1'b0; #1;
    check("R9 no lookup", pred_valid, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_overwrite();
    t_alias();
    t_lowbits();
    t_direct();
    t_same_cycle();
    t_valid();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule